// File: doc/BRIEF.md
# Inverted-Sine-Arch PWM Generator

This block drives the four switches of a single-phase full-bridge inverter. A sine reference of programmable depth is compared against a fast carrier that is read from a table, and a switch pair is pulsed whenever the reference exceeds the carrier. By default the carrier is shaped as one minus a sine arch. It sits at full scale at the edges of each carrier cycle and falls to zero in the middle, so the pulses are wider than they would be with a linear ramp. A select input swaps in a symmetric triangle instead, which gives conventional sinusoidal PWM from the same reference path.

One table step happens every DIV clocks. A reference period is REF_PTS steps long. The carrier phase advances by the frequency ratio Mf on every step, so exactly Mf carrier cycles fit in each period and stay locked to the reference. Switching is unipolar: one pair of switches carries the pulses in the positive half of the reference and the other pair carries them in the negative half. The depth, the ratio and the carrier shape are sampled only at period boundaries, or on every clock while the block is disabled.

Top module: `sine_arch_pwm`

## Requirements
- R1: A synchronous reset forces all four gate outputs and `neg_half_o` low on the following clock. It clears the step index, the carrier phase, the cycle counter and the latched settings (depth, ratio and mode read as 0 until they are next loaded).
- R2: While `en_i` is low, the gates and `neg_half_o` are low from the next clock. The index and the phase return to 0, and the settings are copied from the inputs on every clock.
- R3: Once enabled, the index advances once every DIV clocks. Counting the first enabled rising edge as clock 1, the outputs for index s are visible after clocks DIV*s+1 through DIV*s+DIV.
- R4: Let h be the index modulo H, where H = REF_PTS/2 and F = 2^DW-1. The reference magnitude is floor(4*F*h*(H-h)/H^2). It is scaled by the depth read as unsigned Q1.7, floor(mag*Ma/2^(DW-1)), and clipped to F.
- R5: The carrier phase p is 0 at the start of every period and advances by Mf modulo REF_PTS on every step. With `tri_sel_i`=0 the carrier is F - floor(4*F*p*(REF_PTS-p)/REF_PTS^2).
- R6: With `tri_sel_i`=1 the carrier is F - floor(2*F*min(p, REF_PTS-p)/REF_PTS).
- R7: A pulse is active while the scaled reference is strictly greater than the carrier at the same index. The gates show the result one clock after the index is held. A carrier sample at full scale never yields a pulse.
- R8: For index < H, the pulse drives `gate_o[0]` and `gate_o[1]`, `gate_o[3:2]` stay low and `neg_half_o`=0. For index >= H, the pulse drives `gate_o[2]` and `gate_o[3]`, `gate_o[1:0]` stay low and `neg_half_o`=1.
- R9: For Mf in {2,4,8,16} and Ma from 0.5 to 1.8 (64 to 230), in either carrier mode, each reference period holds exactly Mf pulses: Mf/2 on each switch pair.
- R10: A change to `ma_i`, `mf_i` or `tri_sel_i` while enabled takes effect only from the first step of the next period. The period already running completes with the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low holds the sequence at its start |
| ma_i | input | DW | Modulation depth, unsigned Q1.7 |
| mf_i | input | MF_W | Carrier cycles per reference period |
| tri_sel_i | input | 1 | 1 selects the triangle carrier, 0 the inverted sine arch |
| gate_o | output | 4 | Switch gates; [1:0] positive-half pair, [3:2] negative-half pair |
| neg_half_o | output | 1 | High while the negative reference half is being output |

## Verification
The bench builds the block with the full 256-entry tables and 8-bit samples, but with DIV=2. A whole reference period then lasts only 512 clocks, so several complete periods in both carrier modes, a mid-period settings change and a mid-run reset all fit in a short run. DIV=2 still builds the divider branch of the generate, and the exact clock at which the first pulse appears checks the step spacing. Ratios 4, 8 and 16 combined with depths from 0.5 up into the clipped region test the pulse-count rule both at the widest and at the narrowest carrier cycles.

// File: rtl/sap_pkg.sv
package sap_pkg;

   // Integer sine-arch approximation 4*full*k*(n-k)/n^2, k in [0,n]
   function automatic longint arch_pt(longint k, longint n, longint full);
      return (4 * full * k * (n - k)) / (n * n);
   endfunction

   // Symmetric ramp: full at k=0, zero at k=n/2
   function automatic longint ramp_pt(longint k, longint n, longint full);
      longint m;
      m = (k < n - k) ? k : n - k;
      return full - (2 * full * m) / n;
   endfunction

endpackage

// File: rtl/sap_timebase.sv
module sap_timebase #(
   parameter int RW   = 8,
   parameter int MF_W = 6,
   parameter int DIV  = 16
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            en,
   input  logic [MF_W-1:0] mf,
   output logic            step_o,
   output logic [RW-1:0]   idx_o,
   output logic [RW-1:0]   acc_o,
   output logic [MF_W-1:0] rep_o,
   output logic            last_o
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   logic [RW:0] sum;

   if (DIV == 1) begin : g_nodiv
      assign step_o = en;
   end else begin : g_div
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
         if (rst || !en)                cnt <= '0;
         else if (cnt == CW'(DIV - 1))  cnt <= '0;
         else                           cnt <= cnt + 1'b1;
      end
      assign step_o = en && (cnt == CW'(DIV - 1));
   end

   assign sum    = {1'b0, acc_o} + (RW + 1)'(mf);
   assign last_o = step_o && (&idx_o);

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         idx_o <= '0;
         acc_o <= '0;
         rep_o <= '0;
      end else if (step_o) begin
         idx_o <= idx_o + 1'b1;
         acc_o <= sum[RW-1:0];
         rep_o <= last_o ? '0 : rep_o + MF_W'(sum[RW]);
      end
   end
endmodule

// File: rtl/sap_wave.sv
module sap_wave
   import sap_pkg::*;
#(
   parameter int DW = 8,
   parameter int RW = 8
) (
   input  logic [RW-1:0] idx,
   input  logic [RW-1:0] acc,
   input  logic [DW-1:0] ma,
   input  logic          tri_sel,
   output logic          pulse_o,
   output logic          neg_o,
   output logic [DW-1:0] car_o
);
   localparam int PTS  = 1 << RW;
   localparam int HALF = PTS / 2;
   localparam int FULL = (1 << DW) - 1;

   logic [DW-1:0]   ref_tab [HALF];
   logic [DW-1:0]   inv_tab [PTS];
   logic [DW-1:0]   tri_tab [PTS];
   logic [DW-1:0]   mag, scaled;
   logic [2*DW-1:0] prod;

   for (genvar g = 0; g < HALF; g++) begin : g_ref
      assign ref_tab[g] = DW'(arch_pt(g, HALF, FULL));
   end

   for (genvar g = 0; g < PTS; g++) begin : g_car
      assign inv_tab[g] = DW'(FULL - arch_pt(g, PTS, FULL));
      assign tri_tab[g] = DW'(ramp_pt(g, PTS, FULL));
   end

   assign neg_o  = idx[RW-1];
   assign mag    = ref_tab[idx[RW-2:0]];
   assign prod   = {{DW{1'b0}}, mag} * {{DW{1'b0}}, ma};
   assign scaled = prod[2*DW-1] ? DW'(FULL) : prod[2*DW-2:DW-1];
   assign car_o  = tri_sel ? tri_tab[acc] : inv_tab[acc];
   assign pulse_o = scaled > car_o;
endmodule

// File: rtl/sap_gate.sv
module sap_gate (
   input  logic       clk,
   input  logic       rst,
   input  logic       en,
   input  logic       pulse,
   input  logic       neg,
   output logic [3:0] gate_o,
   output logic       neg_o
);
   always_ff @(posedge clk) begin
      if (rst || !en) begin
         gate_o <= '0;
         neg_o  <= 1'b0;
      end else begin
         gate_o <= neg ? {pulse, pulse, 2'b00} : {2'b00, pulse, pulse};
         neg_o  <= neg;
      end
   end
endmodule

// File: rtl/sine_arch_pwm.sv
module sine_arch_pwm #(
   parameter int DW      = 8,
   parameter int REF_PTS = 256,
   parameter int MF_W    = 6,
   parameter int DIV     = 16
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            en_i,
   input  logic [DW-1:0]   ma_i,
   input  logic [MF_W-1:0] mf_i,
   input  logic            tri_sel_i,
   output logic [3:0]      gate_o,
   output logic            neg_half_o
);
   localparam int RW = $clog2(REF_PTS);

   if (REF_PTS < 8 || (REF_PTS & (REF_PTS - 1)) != 0) begin : g_bad_pts
      $error("REF_PTS must be a power of two of at least 8");
   end
   if (MF_W < 1 || MF_W > RW) begin : g_bad_mf
      $error("MF_W must lie between 1 and log2(REF_PTS)");
   end
   if (DW < 2 || DW > 16) begin : g_bad_dw
      $error("DW must lie between 2 and 16");
   end
   if (DIV < 1) begin : g_bad_div
      $error("DIV must be at least 1");
   end

   logic [DW-1:0]   ma_q, car_w;
   logic [MF_W-1:0] mf_q, rep_w;
   logic            tri_q, step_w, last_w, pulse_w, neg_w;
   logic [RW-1:0]   idx_w, acc_w;

   // settings follow the inputs while idle, else only at a period boundary
   always_ff @(posedge clk) begin
      if (rst) begin
         ma_q  <= '0;
         mf_q  <= '0;
         tri_q <= 1'b0;
      end else if (!en_i || last_w) begin
         ma_q  <= ma_i;
         mf_q  <= mf_i;
         tri_q <= tri_sel_i;
      end
   end

   sap_timebase #(.RW(RW), .MF_W(MF_W), .DIV(DIV)) u_tb (
      .clk(clk), .rst(rst), .en(en_i), .mf(mf_q),
      .step_o(step_w), .idx_o(idx_w), .acc_o(acc_w),
      .rep_o(rep_w), .last_o(last_w)
   );

   sap_wave #(.DW(DW), .RW(RW)) u_wave (
      .idx(idx_w), .acc(acc_w), .ma(ma_q), .tri_sel(tri_q),
      .pulse_o(pulse_w), .neg_o(neg_w), .car_o(car_w)
   );

   sap_gate u_gate (
      .clk(clk), .rst(rst), .en(en_i), .pulse(pulse_w), .neg(neg_w),
      .gate_o(gate_o), .neg_o(neg_half_o)
   );
endmodule

// File: rtl/sine_arch_pwm_chk.sv
module sine_arch_pwm_chk #(
   parameter int DW   = 8,
   parameter int MF_W = 6
) (
   input logic            clk,
   input logic            rst,
   input logic            en,
   input logic            step,
   input logic            last,
   input logic [DW-1:0]   ma_q,
   input logic [MF_W-1:0] mf_q,
   input logic            tri_q,
   input logic [MF_W-1:0] rep,
   input logic [DW-1:0]   car,
   input logic [3:0]      gate,
   input logic            neg_half
);
   localparam logic [DW-1:0] FULL = '1;

   assert_reset_low_R1: assert property (@(posedge clk)
      rst |=> (gate == 4'b0000 && !neg_half));

   assert_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
      !en |=> (gate == 4'b0000 && !neg_half));

   assert_full_car_gap_R7: assert property (@(posedge clk) disable iff (rst)
      (en && car == FULL) |=> (gate == 4'b0000));

   assert_pair_excl_R8: assert property (@(posedge clk) disable iff (rst)
      !((|gate[1:0]) && (|gate[3:2])));

   assert_pair_match_R8: assert property (@(posedge clk) disable iff (rst)
      (gate[0] == gate[1]) && (gate[2] == gate[3]));

   assert_half_steer_R8: assert property (@(posedge clk) disable iff (rst)
      neg_half ? (gate[1:0] == 2'b00) : (gate[3:2] == 2'b00));

   assert_cycle_count_R9: assert property (@(posedge clk) disable iff (rst)
      (en && step && last && mf_q != '0) |-> (rep == mf_q - 1'b1));

   assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (en && !last) |=> ($stable(ma_q) && $stable(mf_q) && $stable(tri_q)));
endmodule

bind sine_arch_pwm sine_arch_pwm_chk #(.DW(DW), .MF_W(MF_W)) u_chk (
   .clk(clk), .rst(rst), .en(en_i), .step(step_w), .last(last_w),
   .ma_q(ma_q), .mf_q(mf_q), .tri_q(tri_q), .rep(rep_w), .car(car_w),
   .gate(gate_o), .neg_half(neg_half_o)
);

// File: tb/tb_sine_arch_pwm.sv
module tb_sine_arch_pwm;
   localparam int CLK_NS = 10;
   localparam int N  = 256;
   localparam int H  = N / 2;
   localparam int DV = 2;
   localparam int F  = 255;
   localparam int PER = N * DV;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en = 1'b0;
   logic [7:0] ma = '0;
   logic [5:0] mf = '0;
   logic       tri_sel = 1'b0;
   logic [3:0] gate;
   logic       neg_half;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   bit cnt_on = 0;
   int edges = 0;
   logic prv0 = 1'b0, prv2 = 1'b0;

   // behavioural model state
   int m_div = 0, m_idx = 0, m_acc = 0, m_ma = 0, m_mf = 0;
   bit m_tri = 0;

   always #(CLK_NS / 2) clk = ~clk;

   sine_arch_pwm #(.DW(8), .REF_PTS(N), .MF_W(6), .DIV(DV)) dut (
      .clk(clk), .rst(rst), .en_i(en), .ma_i(ma), .mf_i(mf),
      .tri_sel_i(tri_sel), .gate_o(gate), .neg_half_o(neg_half)
   );

   function automatic int ref_mag(int h);
      return (4 * F * h * (H - h)) / (H * H);
   endfunction

   function automatic int inv_car(int p);
      return F - (4 * F * p * (N - p)) / (N * N);
   endfunction

   function automatic int tri_car(int p);
      int m;
      m = (p < N - p) ? p : N - p;
      return F - (2 * F * m) / N;
   endfunction

   function automatic bit fire(int idx, int acc, int dep, bit tri_m);
      int sc;
      sc = (ref_mag(idx % H) * dep) / 128;
      if (sc > F) sc = F;
      return sc > (tri_m ? tri_car(acc) : inv_car(acc));
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the model (R3 R4 R5 R6 R7 R8 R10)
   always @(negedge clk) begin
      logic [3:0] e_gate;
      logic       e_half;
      bit         p, stp;
      if (rst || !en) begin
         e_gate = 4'b0000;
         e_half = 1'b0;
      end else begin
         p      = fire(m_idx, m_acc, m_ma, m_tri);
         e_half = (m_idx >= H);
         e_gate = e_half ? {p, p, 2'b00} : {2'b00, p, p};
      end
      if (!done)
         chk({neg_half, gate} == {e_half, e_gate},
             "cycle compare R3 R4 R5 R6 R7 R8 R10", {neg_half, gate}, {e_half, e_gate});
      if (rst) begin
         m_div = 0; m_idx = 0; m_acc = 0; m_ma = 0; m_mf = 0; m_tri = 0;
      end else if (!en) begin
         m_div = 0; m_idx = 0; m_acc = 0;
         m_ma = ma; m_mf = mf; m_tri = tri_sel;
      end else begin
         stp   = (m_div == DV - 1);
         m_div = stp ? 0 : m_div + 1;
         if (stp) begin
            m_acc = (m_acc + m_mf) % N;
            if (m_idx == N - 1) begin
               m_ma = ma; m_mf = mf; m_tri = tri_sel;
            end
            m_idx = (m_idx + 1) % N;
         end
      end
   end

   // pulse counter: rising edges on either switch pair
   always @(negedge clk) begin
      if (cnt_on) begin
         if (gate[0] && !prv0) edges++;
         if (gate[2] && !prv2) edges++;
      end
      prv0 = gate[0];
      prv2 = gate[2];
   end

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic count_run(int dep, int ratio, bit tri_m, int periods, int exp, string tag);
      en = 1'b0;
      ma = 8'(dep); mf = 6'(ratio); tri_sel = tri_m;
      wait_cyc(2);
      edges = 0;
      cnt_on = 1;
      en = 1'b1;
      wait_cyc(periods * PER + 4);
      cnt_on = 0;
      chk(edges == exp, tag, edges, exp);
      en = 1'b0;
      wait_cyc(2);
   endtask

   initial begin
      int first_s, got;
      wait_cyc(4);
      chk(gate == 4'b0000 && !neg_half, "R1 outputs low in reset", {neg_half, gate}, 0);
      rst = 1'b0;

      // idle with live settings: nothing must toggle
      ma = 8'd102; mf = 6'd8; tri_sel = 1'b0;
      wait_cyc(6);
      chk(gate == 4'b0000 && !neg_half, "R2 outputs low while idle", {neg_half, gate}, 0);

      // first pulse position gives the step spacing
      ma = 8'd128; mf = 6'd8; tri_sel = 1'b0;
      wait_cyc(2);
      first_s = -1;
      for (int s = 0; s < N && first_s < 0; s++)
         if (fire(s, (s * 8) % N, 128, 1'b0)) first_s = s;
      en = 1'b1;
      got = -1;
      for (int k = 1; k <= PER && got < 0; k++) begin
         @(negedge clk); #1;
         if (gate[0]) got = k;
      end
      chk(got == DV * first_s + 1, "R3 clock of first pulse", got, DV * first_s + 1);
      wait_cyc(200);
      en = 1'b0;
      wait_cyc(1);
      chk(gate == 4'b0000 && !neg_half, "R2 outputs drop when disabled", {neg_half, gate}, 0);
      wait_cyc(2);

      count_run(102, 8, 1'b0, 2, 16, "R9 R5 inverted arch Mf=8 Ma=0.8");
      count_run(102, 8, 1'b1, 2, 16, "R9 R6 triangle Mf=8 Ma=0.8");
      count_run(128, 4, 1'b0, 1, 4,  "R9 R5 inverted arch Mf=4 Ma=1.0");
      count_run(64, 16, 1'b1, 1, 16, "R9 R6 triangle Mf=16 Ma=0.5");
      count_run(64, 16, 1'b0, 1, 16, "R9 R5 inverted arch Mf=16 Ma=0.5");
      count_run(230, 8, 1'b0, 1, 8,  "R9 R4 clipped depth Mf=8 Ma=1.8");

      // settings change in mid-period: old ratio finishes the period (R10)
      ma = 8'd102; mf = 6'd8; tri_sel = 1'b0;
      wait_cyc(2);
      en = 1'b1;
      wait_cyc(PER / 2);
      mf = 6'd4; tri_sel = 1'b1;
      edges = 0;
      cnt_on = 1;
      wait_cyc(PER / 2 + PER + 4);
      cnt_on = 0;
      chk(edges == 8, "R10 old half plus new period", edges, 8);

      // reset while running (R1)
      wait_cyc(PER / 3);
      rst = 1'b1;
      wait_cyc(1);
      chk(gate == 4'b0000 && !neg_half, "R1 outputs low after mid-run reset", {neg_half, gate}, 0);
      rst = 1'b0;
      edges = 0;
      cnt_on = 1;
      wait_cyc(PER - 8);
      cnt_on = 0;
      chk(edges == 0, "R1 cleared settings give no pulses", edges, 0);
      wait_cyc(PER);
      en = 1'b0;
      wait_cyc(4);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_NS * 150000);
      if (!done) begin
         done = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule